// File: doc/BRIEF.md
# Harvester Calibration and Flyback Sequencer

This controller keeps a capacitive vibration energy harvester near its best operating window. It alternates between two modes. A calibration pass first forces the flyback switch on, so that the store capacitor falls to the reservoir voltage. While the switch is held on, one conversion of the reservoir voltage is taken. The switch is then released and charge pumping resumes. The store voltage is sampled at a fixed tick period until it stops rising, which means it has saturated. From the reservoir code and the saturation code the block derives two flyback thresholds, at one tenth and six tenths of the measured span above the reservoir level.

In normal mode the block reads the store voltage through the same ADC handshake at a programmable tick interval. It closes the flyback switch when the store voltage reaches the upper threshold and opens it when the voltage falls to the lower one. The ADC is enabled only while a conversion is pending. A new calibration starts after a programmable number of ticks in normal mode. All time intervals count pulses of `tick_i`, so the block runs from any fast clock.

Top module: `harv_cal_seq`

## Requirements
- R1: While `rst_ni` is low, `flyback_o`, `adc_start_o`, `sat_timeout_o`, `ures_o`, `umax_o`, `thr_lo_o` and `thr_hi_o` are all zero and `cal_active_o` is one.
- R2: Every calibration holds `flyback_o` high with `cal_active_o` high for HOLD_TICKS ticks, plus at most three clock cycles. In that window exactly one conversion is started, and its result appears on `ures_o`.
- R3: After the hold, `flyback_o` is low. Store samples are started at least SAMP_TICKS ticks apart, and no more than SAMP_TICKS ticks plus twelve cycles apart when the ADC answers in four cycles.
- R4: Saturation is the first store sample whose 8-bit code equals that of the sample just before it. That code is the maximum used for the thresholds.
- R5: Let span = max − reservoir code, or 0 when max is below the reservoir code. Then `thr_lo_o` = reservoir + floor(span/10) and `thr_hi_o` = reservoir + floor(6·span/10), each saturated to 8 bits. Both are valid when `cal_active_o` falls.
- R6: If MAX_SAMPLES store samples pass with no two consecutive codes equal, the last code becomes the maximum and `sat_timeout_o` rises. The flag clears when the next calibration starts.
- R7: In normal mode, a conversion result ≥ `thr_hi_o` sets `flyback_o`. A result ≤ `thr_lo_o` and below `thr_hi_o` clears it. Any other result leaves it unchanged. The thresholds do not change during normal mode.
- R8: In normal mode `adc_en_o` is high only from a conversion start to its done, `umax_o` reads 0, and `ures_o` keeps the last reservoir code.
- R9: A new calibration (`cal_active_o` rising) begins `cal_period_i` ticks after the previous one ended, plus the length of any conversion that is pending at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick; all intervals count these |
| cal_period_i | input | 16 | Ticks spent in normal mode between calibrations |
| norm_interval_i | input | 16 | Ticks between store samples in normal mode |
| adc_en_o | output | 1 | ADC power enable |
| adc_start_o | output | 1 | One-cycle conversion request |
| adc_done_i | input | 1 | Conversion result valid |
| adc_data_i | input | 8 | Conversion result code |
| flyback_o | output | 1 | Flyback switch drive |
| cal_active_o | output | 1 | High during calibration |
| sat_timeout_o | output | 1 | Last saturation search ended on the sample limit |
| ures_o | output | 8 | Reservoir code from the last calibration |
| umax_o | output | 8 | Saturation code; zero outside calibration |
| thr_lo_o | output | 8 | Lower flyback threshold |
| thr_hi_o | output | 8 | Upper flyback threshold |

## Verification
A wrong sequencer state shows at the ports within one conversion. Examples are a missing or extra start pulse, the flyback drive wrong for the phase, or `adc_en_o` high during an idle normal-mode wait. A wrong saturation decision or threshold arithmetic shows in `thr_lo_o` and `thr_hi_o` in the cycle `cal_active_o` falls. A flaw in the hysteresis shows on `flyback_o` in the cycle after the done that should have moved it. Timer faults shift the hold length, the sample spacing or the recalibration time by whole ticks, and these are measured directly.

// File: rtl/harv_pkg.sv
package harv_pkg;
  typedef enum logic [2:0] {
    S_INIT,
    S_HOLD,
    S_SWAIT,
    S_SCONV,
    S_CALC,
    S_NWAIT,
    S_NCONV
  } seq_state_e;
endpackage

// File: rtl/harv_tick_timer.sv
module harv_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/harv_thresh_calc.sv
module harv_thresh_calc #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 16
) (
  input  logic [DATA_W-1:0] ures_i,
  input  logic [DATA_W-1:0] umax_i,
  output logic [DATA_W-1:0] thr_lo_o,
  output logic [DATA_W-1:0] thr_hi_o
);
  localparam int PW = DATA_W + FRAC_W;
  // ceil of tenths in Q.FRAC_W; the tiny excess never crosses an integer for DATA_W-bit spans
  localparam int unsigned K_LO = ((1 << FRAC_W) + 9) / 10;
  localparam int unsigned K_HI = ((6 << FRAC_W) + 9) / 10;

  logic [DATA_W-1:0] span;
  logic [DATA_W-1:0] thr [2];

  assign span = (umax_i > ures_i) ? (umax_i - ures_i) : '0;

  for (genvar g = 0; g < 2; g++) begin : g_thr
    localparam int unsigned K = (g == 0) ? K_LO : K_HI;
    logic [PW-1:0]     prod;
    logic [DATA_W-1:0] frac;
    logic [DATA_W:0]   sum;
    assign prod = PW'(span) * PW'(K);
    assign frac = prod[PW-1:FRAC_W];
    assign sum  = {1'b0, ures_i} + {1'b0, frac};
    assign thr[g] = sum[DATA_W] ? {DATA_W{1'b1}} : sum[DATA_W-1:0];
  end

  assign thr_lo_o = thr[0];
  assign thr_hi_o = thr[1];
endmodule

// File: rtl/harv_cal_seq.sv
module harv_cal_seq
  import harv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int HOLD_TICKS  = 200,
  parameter int SAMP_TICKS  = 36,
  parameter int MAX_SAMPLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cal_period_i,
  input  logic [CNT_W-1:0]  norm_interval_i,
  output logic              adc_en_o,
  output logic              adc_start_o,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              flyback_o,
  output logic              cal_active_o,
  output logic              sat_timeout_o,
  output logic [DATA_W-1:0] ures_o,
  output logic [DATA_W-1:0] umax_o,
  output logic [DATA_W-1:0] thr_lo_o,
  output logic [DATA_W-1:0] thr_hi_o
);
  localparam int SCNT_W = $clog2(MAX_SAMPLES + 1);
  localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(MAX_SAMPLES - 1);

  seq_state_e state_q, state_d;
  logic              start_q, start_d;
  logic              fb_q, fb_d;
  logic              got_q, have_prev_q, to_q;
  logic [SCNT_W-1:0] scnt_q;
  logic [DATA_W-1:0] ures_q, umax_q, prev_q, thr_lo_q, thr_hi_q;
  logic [DATA_W-1:0] calc_lo, calc_hi;
  logic [CNT_W-1:0]  ph_limit;
  logic ph_load, ph_done, per_load, per_done;
  logic cap_ures, cap_max, keep_prev, set_to, latch_thr;

  always_comb begin
    unique case (state_q)
      S_HOLD:  ph_limit = CNT_W'(HOLD_TICKS);
      S_SWAIT: ph_limit = CNT_W'(SAMP_TICKS);
      default: ph_limit = norm_interval_i;
    endcase
  end

  harv_tick_timer #(.CNT_W(CNT_W)) u_phase_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ph_load),
    .tick_i  (tick_i),
    .limit_i (ph_limit),
    .done_o  (ph_done)
  );

  harv_tick_timer #(.CNT_W(CNT_W)) u_period_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (per_load),
    .tick_i  (tick_i),
    .limit_i (cal_period_i),
    .done_o  (per_done)
  );

  harv_thresh_calc #(.DATA_W(DATA_W)) u_calc (
    .ures_i   (ures_q),
    .umax_i   (umax_q),
    .thr_lo_o (calc_lo),
    .thr_hi_o (calc_hi)
  );

  always_comb begin
    state_d   = state_q;
    start_d   = 1'b0;
    fb_d      = fb_q;
    ph_load   = 1'b0;
    per_load  = 1'b0;
    cap_ures  = 1'b0;
    cap_max   = 1'b0;
    keep_prev = 1'b0;
    set_to    = 1'b0;
    latch_thr = 1'b0;
    unique case (state_q)
      S_INIT: begin
        state_d = S_HOLD;
        start_d = 1'b1;
        ph_load = 1'b1;
        fb_d    = 1'b1;
      end
      S_HOLD: begin
        cap_ures = adc_done_i && !got_q;
        if (ph_done && (got_q || adc_done_i)) begin
          state_d = S_SWAIT;
          ph_load = 1'b1;
          fb_d    = 1'b0;
        end
      end
      S_SWAIT: begin
        if (ph_done) begin
          state_d = S_SCONV;
          start_d = 1'b1;
        end
      end
      S_SCONV: begin
        if (adc_done_i) begin
          if (have_prev_q && (adc_data_i == prev_q)) begin
            state_d = S_CALC;
            cap_max = 1'b1;
          end else if (scnt_q == SCNT_LAST) begin
            state_d = S_CALC;
            cap_max = 1'b1;
            set_to  = 1'b1;
          end else begin
            state_d   = S_SWAIT;
            ph_load   = 1'b1;
            keep_prev = 1'b1;
          end
        end
      end
      S_CALC: begin
        state_d   = S_NWAIT;
        ph_load   = 1'b1;
        per_load  = 1'b1;
        latch_thr = 1'b1;
      end
      S_NWAIT: begin
        if (per_done) begin
          state_d = S_HOLD;
          start_d = 1'b1;
          ph_load = 1'b1;
          fb_d    = 1'b1;
        end else if (ph_done) begin
          state_d = S_NCONV;
          start_d = 1'b1;
        end
      end
      S_NCONV: begin
        if (adc_done_i) begin
          state_d = S_NWAIT;
          ph_load = 1'b1;
          if (adc_data_i >= thr_hi_q)      fb_d = 1'b1;
          else if (adc_data_i <= thr_lo_q) fb_d = 1'b0;
        end
      end
      default: state_d = S_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_INIT;
      start_q     <= 1'b0;
      fb_q        <= 1'b0;
      got_q       <= 1'b0;
      have_prev_q <= 1'b0;
      to_q        <= 1'b0;
      scnt_q      <= '0;
      ures_q      <= '0;
      umax_q      <= '0;
      prev_q      <= '0;
      thr_lo_q    <= '0;
      thr_hi_q    <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      fb_q    <= fb_d;
      if (state_d == S_HOLD && state_q != S_HOLD) begin
        got_q <= 1'b0;
        to_q  <= 1'b0;
      end
      if (cap_ures) begin
        ures_q <= adc_data_i;
        got_q  <= 1'b1;
      end
      if (state_q == S_HOLD && state_d == S_SWAIT) begin
        have_prev_q <= 1'b0;
        scnt_q      <= '0;
      end
      if (keep_prev) begin
        prev_q      <= adc_data_i;
        have_prev_q <= 1'b1;
        scnt_q      <= scnt_q + 1'b1;
      end
      if (cap_max) umax_q <= adc_data_i;
      if (set_to)  to_q   <= 1'b1;
      if (latch_thr) begin
        thr_lo_q <= calc_lo;
        thr_hi_q <= calc_hi;
        umax_q   <= '0;
      end
    end
  end

  assign cal_active_o  = (state_q != S_NWAIT) && (state_q != S_NCONV);
  assign adc_en_o      = cal_active_o || (state_q == S_NCONV);
  assign adc_start_o   = start_q;
  assign flyback_o     = fb_q;
  assign sat_timeout_o = to_q;
  assign ures_o        = ures_q;
  assign umax_o        = umax_q;
  assign thr_lo_o      = thr_lo_q;
  assign thr_hi_o      = thr_hi_q;
endmodule

// File: rtl/harv_cal_seq_chk.sv
module harv_cal_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_en_o,
  input logic              adc_start_o,
  input logic              adc_done_i,
  input logic [DATA_W-1:0] adc_data_i,
  input logic              flyback_o,
  input logic              cal_active_o,
  input logic [DATA_W-1:0] umax_o,
  input logic [DATA_W-1:0] thr_lo_o,
  input logic [DATA_W-1:0] thr_hi_o
);
  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  assert_en_on_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> adc_en_o);

  assert_umax_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_active_o |-> (umax_o == '0));

  assert_thr_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_lo_o <= thr_hi_o);

  assert_hyst_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cal_active_o && adc_en_o && adc_done_i && adc_data_i >= thr_hi_o) |=> flyback_o);

  assert_hyst_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cal_active_o && adc_en_o && adc_done_i && adc_data_i <= thr_lo_o &&
     adc_data_i < thr_hi_o) |=> !flyback_o);

  assert_thr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cal_active_o && !$past(cal_active_o)) |-> ($stable(thr_lo_o) && $stable(thr_hi_o)));
endmodule

bind harv_cal_seq harv_cal_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .adc_en_o     (adc_en_o),
  .adc_start_o  (adc_start_o),
  .adc_done_i   (adc_done_i),
  .adc_data_i   (adc_data_i),
  .flyback_o    (flyback_o),
  .cal_active_o (cal_active_o),
  .umax_o       (umax_o),
  .thr_lo_o     (thr_lo_o),
  .thr_hi_o     (thr_hi_o)
);

// File: tb/harv_cal_seq_test.sv
`timescale 1ns/1ps
module harv_cal_seq_test;
  localparam int HOLD = 200;
  localparam int SAMP = 36;
  localparam int MAXS = 16;
  localparam int PER  = 400;
  localparam int NV   = 7;
  // reservoir, plateau, ramp step, expected lo, expected hi, expected timeout
  localparam int VU [NV] = '{50,   0, 100, 120, 10,  7,  33};
  localparam int VM [NV] = '{200, 255, 100,  80, 250, 17, 252};
  localparam int VS [NV] = '{30,  40,  10,  10,  1,   5,  50};
  localparam int EL [NV] = '{65,  25, 100, 120, 11,  8,  54};
  localparam int EH [NV] = '{140, 153, 100, 120, 19, 13, 164};
  localparam int ET [NV] = '{0,   0,   0,   0,   1,   0,   0};

  logic clk = 0;
  logic rst_ni = 0;
  logic tick = 1;
  logic [15:0] cal_period = 16'(PER);
  logic [15:0] norm_int = 16'd20;
  logic adc_done = 0;
  logic [7:0] adc_data = 0;
  logic adc_en, adc_start, flyback, cal_active, sat_to;
  logic [7:0] ures, umax, thr_lo, thr_hi;

  int tests = 0, fails = 0, cyc = 0;
  int m_ures = 0, m_umax = 0, m_step = 1, norm_val = 0;
  int hold_cnt = 0, hold_convs = 0, last_samp = -1, sp_min = 1 << 30, sp_max = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  harv_cal_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .cal_period_i(cal_period), .norm_interval_i(norm_int),
    .adc_en_o(adc_en), .adc_start_o(adc_start),
    .adc_done_i(adc_done), .adc_data_i(adc_data),
    .flyback_o(flyback), .cal_active_o(cal_active), .sat_timeout_o(sat_to),
    .ures_o(ures), .umax_o(umax), .thr_lo_o(thr_lo), .thr_hi_o(thr_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  always @(negedge clk) if (rst_ni && cal_active && flyback) hold_cnt++;

  // ADC model: answers four cycles after a start
  initial begin : adc_model
    int k = 0;
    int v;
    forever begin
      @(posedge clk); #1;
      if (adc_start) begin
        if (cal_active && flyback) begin
          k = 0; v = m_ures; hold_convs++;
        end else if (cal_active) begin
          k++;
          v = m_ures + k * m_step;
          if (v > m_umax) v = m_umax;
          if (last_samp >= 0) begin
            if (cyc - last_samp < sp_min) sp_min = cyc - last_samp;
            if (cyc - last_samp > sp_max) sp_max = cyc - last_samp;
          end
          last_samp = cyc;
        end else begin
          v = -1;
        end
        repeat (3) @(posedge clk);
        #1;
        adc_done = 1;
        adc_data = 8'((v < 0) ? norm_val : v);
        @(posedge clk); #1;
        adc_done = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic do_norm(input int v, input int exp_fb, input string req);
    norm_val = v;
    repeat (2) @(posedge adc_done);
    @(negedge adc_done);
    @(negedge clk);
    chk(req, int'(flyback), exp_fb);
    chk("R8 adc_en idle in normal", int'(adc_en), 0);
  endtask

  initial begin : main
    int t_fall = 0;
    m_ures = VU[0]; m_umax = VM[0]; m_step = VS[0];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flyback", int'(flyback), 0);
    chk("R1 adc_start", int'(adc_start), 0);
    chk("R1 thr_lo", int'(thr_lo), 0);
    chk("R1 thr_hi", int'(thr_hi), 0);
    chk("R1 ures", int'(ures), 0);
    chk("R1 umax", int'(umax), 0);
    chk("R1 timeout", int'(sat_to), 0);
    chk("R1 cal_active", int'(cal_active), 1);
    @(posedge clk); #1 rst_ni = 1;

    for (int i = 0; i < NV; i++) begin
      if (i > 0) begin
        m_ures = VU[i]; m_umax = VM[i]; m_step = VS[i];
        @(posedge cal_active);
        chk_rng("R9 recal period", cyc - t_fall, PER, PER + 10);
      end
      @(negedge cal_active);
      @(negedge clk);
      t_fall = cyc;
      chk("R2 ures captured", int'(ures), VU[i]);
      chk_rng("R2 hold length", hold_cnt, HOLD, HOLD + 3);
      chk("R2 one reservoir conversion", hold_convs, 1);
      chk_rng("R3 sample spacing min", sp_min, SAMP, SAMP + 12);
      chk_rng("R3 sample spacing max", sp_max, SAMP, SAMP + 12);
      chk("R4 R5 thr_lo", int'(thr_lo), EL[i]);
      chk("R4 R5 thr_hi", int'(thr_hi), EH[i]);
      chk("R6 timeout flag", int'(sat_to), ET[i]);
      chk("R8 umax zero in normal", int'(umax), 0);
      chk("R8 adc_en off after cal", int'(adc_en), 0);
      hold_cnt = 0; hold_convs = 0; last_samp = -1; sp_min = 1 << 30; sp_max = 0;
    end

    // R7 hysteresis with lo=54 hi=164
    cal_period = 16'hFFFF;
    do_norm(100, 0, "R7 between, off stays off");
    do_norm(164, 1, "R7 at upper turns on");
    do_norm(100, 1, "R7 between, on stays on");
    do_norm(55,  1, "R7 above lower stays on");
    do_norm(54,  0, "R7 at lower turns off");
    do_norm(163, 0, "R7 below upper stays off");
    do_norm(255, 1, "R7 full scale turns on");
    do_norm(0,   0, "R7 zero turns off");
    chk("R8 ures kept", int'(ures), VU[NV-1]);
    chk("R7 thr_lo unchanged", int'(thr_lo), EL[NV-1]);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule